// File: doc/BRIEF.md
# Display Line Transfer and Dot Polarity Control

This block sits between the serial capture stage of a column driver and its output stage. A capture stage fills a line register with one code per channel. When the load strobe rises, this block copies the whole line into an output register that holds the codes now being driven. At the same clock it stores the polarity select. From that stored bit every channel receives a polarity flag, and adjacent channels always take opposite polarity. This gives dot inversion.

After each transfer the analog outputs need a fixed number of clocks for offset cancellation. A small state machine counts that interval and raises a ready flag once it has ended. The state machine has three states:

- ST_COLD: the state after reset, before any load has occurred.
- ST_SETTLE: the count is running.
- ST_READY: the outputs have settled.

It has two transitions:

- T_LOAD: taken from any state on a load edge. It goes to ST_SETTLE and clears the count.
- T_DONE: taken from ST_SETTLE to ST_READY when the count is complete.

A load is accepted at any moment, including while the capture stage is still busy filling the line.

Top module: `sdrv_line_xfer`

## Requirements
- R1: At the first rising clock edge at which `load_i` is sampled high after being sampled low, `codes_o` takes the value of `line_i`. Channel k (1-based) occupies bits [(k-1)*W +: W].
- R2: `pol_sel_i` is stored at that same edge. When it is 1, even-numbered channels are flagged positive (`pol_pos_o[k-1]`=1 for even k) and odd-numbered channels are flagged negative. When it is 0, the assignment is the reverse.
- R3: A load is accepted whatever the level of `cap_busy_i`. Channels whose field in `line_i` was not rewritten since the previous load keep their previous code.
- R4: Holding `load_i` high for several cycles produces one transfer only. Changes of `line_i` or `pol_sel_i` while the strobe stays high have no effect until the next rising edge of the strobe.
- R5: `ready_o` is low from the load edge onward and goes high exactly SETTLE_CYC (default 253) rising clock edges after the load edge.
- R6: A load edge that arrives while the count is running clears `ready_o` and restarts the full count.
- R7: After reset, all codes are zero, the stored polarity is 0 (odd channels positive) and `ready_o` is low until a load has settled.
- R8: Between load edges, `codes_o` and `pol_pos_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe, sampled synchronously |
| pol_sel_i | input | 1 | Polarity select, stored on a load edge |
| cap_busy_i | input | 1 | High while the capture stage is filling the line |
| line_i | input | CH*W | Sampled line, CH codes of W bits |
| codes_o | output | CH*W | Codes being driven on the channels |
| pol_pos_o | output | CH | Per-channel polarity flag, 1 = positive |
| ready_o | output | 1 | Settling interval has ended |

## Verification
The bench counts clocks around the settling boundary. It expects `ready_o` to be low one edge before the end of the count and high on the final edge. A counter that is off by one, or that starts at the wrong edge, misses one of these two checks. It reloads midway through a count to confirm that the count restarts; a design that ignored the second edge would report ready about 100 cycles early. It holds the strobe high while changing the line and the polarity, which exposes a level-sensitive copy in place of an edge-triggered one. It also reloads with most channels unchanged while the capture stage is busy, so that a design which blocks or clears on busy shows stale or zero codes.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
    typedef enum logic [1:0] {
        ST_COLD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_READY  = 2'd2
    } settle_state_t;
endpackage

// File: rtl/sdrv_strobe_edge.sv
module sdrv_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/sdrv_line_hold.sv
module sdrv_line_hold #(
    parameter int CH = 384,
    parameter int W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            pol_sel_i,
    input  logic [CH*W-1:0] line_i,
    output logic [CH*W-1:0] codes_o,
    output logic [CH-1:0]   pol_pos_o
);
    localparam int LW = CH * W;

    logic [LW-1:0] codes_q;
    logic          pol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes_q <= '0;
            pol_q   <= 1'b0;
        end else if (take_i) begin
            codes_q <= line_i;
            pol_q   <= pol_sel_i;
        end
    end

    // index i carries channel number i+1: odd index means even channel
    for (genvar i = 0; i < CH; i++) begin : g_pol
        if (i % 2 == 1) begin : g_even_ch
            assign pol_pos_o[i] = pol_q;
        end else begin : g_odd_ch
            assign pol_pos_o[i] = ~pol_q;
        end
    end

    assign codes_o = codes_q;
endmodule

// File: rtl/sdrv_settle_fsm.sv
module sdrv_settle_fsm #(
    parameter int SETTLE_CYC = 253
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_rise_i,
    output logic ready_o
);
    import sdrv_pkg::*;

    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    settle_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_COLD, ST_READY: begin
                if (load_rise_i) begin           // T_LOAD
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end
            end
            ST_SETTLE: begin
                if (load_rise_i) begin           // T_LOAD (restart)
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin // T_DONE
                    state_d = ST_READY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_COLD;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_READY: ready_o = 1'b1;
            default:  ready_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdrv_line_xfer.sv
module sdrv_line_xfer #(
    parameter int CH         = 384,
    parameter int W          = 8,
    parameter int SETTLE_CYC = 253
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            pol_sel_i,
    input  logic            cap_busy_i,
    input  logic [CH*W-1:0] line_i,
    output logic [CH*W-1:0] codes_o,
    output logic [CH-1:0]   pol_pos_o,
    output logic            ready_o
);
    logic load_rise;

    sdrv_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (load_i),
        .rise_o   (load_rise)
    );

    sdrv_line_hold #(.CH(CH), .W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (load_rise),
        .pol_sel_i (pol_sel_i),
        .line_i    (line_i),
        .codes_o   (codes_o),
        .pol_pos_o (pol_pos_o)
    );

    sdrv_settle_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_rise_i (load_rise),
        .ready_o     (ready_o)
    );
endmodule

// File: rtl/sdrv_line_xfer_chk.sv
module sdrv_line_xfer_chk #(
    parameter int CH         = 384,
    parameter int W          = 8,
    parameter int SETTLE_CYC = 253
) (
    input logic            clk,
    input logic            rst_n,
    input logic            load_i,
    input logic            pol_sel_i,
    input logic            cap_busy_i,
    input logic [CH*W-1:0] line_i,
    input logic [CH*W-1:0] codes_o,
    input logic [CH-1:0]   pol_pos_o,
    input logic            ready_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(SETTLE_CYC);

    logic          ld_prev;
    logic          seen;
    logic [CW-1:0] since;
    logic          ev;

    assign ev = load_i & ~ld_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_prev <= 1'b0;
            seen    <= 1'b0;
            since   <= '0;
        end else begin
            ld_prev <= load_i;
            if (ev) begin
                seen  <= 1'b1;
                since <= '0;
            end else if (since != FULL) begin
                since <= since + 1'b1;
            end
        end
    end

    // R1
    capture_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> codes_o == $past(line_i));

    // R2
    pol_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (pol_pos_o[1] == $past(pol_sel_i)) && (pol_pos_o[0] != $past(pol_sel_i)));

    // R3
    busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && cap_busy_i) |=> codes_o == $past(line_i));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(codes_o) && $stable(pol_pos_o));

    // R5
    ready_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (seen && since == FULL));

    // R5
    ready_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && since == FULL) |-> ready_o);

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ready_o);
endmodule

bind sdrv_line_xfer sdrv_line_xfer_chk #(.CH(CH), .W(W), .SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/sim_sdrv_line_xfer.sv
`timescale 1ns/1ps
module sim_sdrv_line_xfer;
    localparam int CH = 384;
    localparam int W  = 8;
    localparam int ST = 253;
    localparam int LW = CH * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          pol_sel_i = 1'b0;
    logic          cap_busy_i = 1'b0;
    logic [LW-1:0] line_i = '0;
    logic [LW-1:0] codes_o;
    logic [CH-1:0] pol_pos_o;
    logic          ready_o;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [LW-1:0] m_codes = '0;
    logic          m_pol = 1'b0;
    logic          m_ldq = 1'b0;
    logic          m_run = 1'b0;
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    sdrv_line_xfer #(.CH(CH), .W(W), .SETTLE_CYC(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .pol_sel_i(pol_sel_i),
        .cap_busy_i(cap_busy_i), .line_i(line_i), .codes_o(codes_o),
        .pol_pos_o(pol_pos_o), .ready_o(ready_o)
    );

    function automatic logic [CH-1:0] exp_pos(input logic pol);
        logic [CH-1:0] v;
        for (int i = 0; i < CH; i++) begin
            // channel number i+1 is even when i is odd
            v[i] = (i % 2 == 1) ? pol : ~pol;
        end
        return v;
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] v;
        for (int i = 0; i < CH; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic chk_codes(input string tag, input logic [LW-1:0] exp);
        n_chk++;
        if (codes_o !== exp) begin
            n_fail++;
            $display("FAIL %s codes: actual %h expected %h", tag, codes_o[63:0], exp[63:0]);
        end
    endtask

    task automatic chk_pos(input string tag, input logic [CH-1:0] exp);
        n_chk++;
        if (pol_pos_o !== exp) begin
            n_fail++;
            $display("FAIL %s pol flags: actual %h expected %h", tag, pol_pos_o[31:0], exp[31:0]);
        end
    endtask

    task automatic chk_ready(input string tag, input logic exp);
        n_chk++;
        if (ready_o !== exp) begin
            n_fail++;
            $display("FAIL %s ready: actual %b expected %b", tag, ready_o, exp);
        end
    endtask

    // one clock: update model at posedge, compare at negedge
    task automatic tick(input string tc, input string tp, input string tr);
        @(posedge clk);
        if (load_i && !m_ldq) begin
            m_codes = line_i;
            m_pol   = pol_sel_i;
            m_cnt   = 0;
            m_run   = 1'b1;
        end else if (m_run && m_cnt < ST) begin
            m_cnt++;
        end
        m_ldq = load_i;
        @(negedge clk);
        chk_codes(tc, m_codes);
        chk_pos(tp, exp_pos(m_pol));
        chk_ready(tr, m_run && m_cnt >= ST);
    endtask

    task automatic ticks(input int n, input string tc, input string tp, input string tr);
        for (int k = 0; k < n; k++) tick(tc, tp, tr);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [LW-1:0] nl;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk_codes("R7", '0);
        chk_pos("R7", exp_pos(1'b0));
        chk_ready("R7", 1'b0);
        ticks(5, "R8", "R8", "R7");

        // R1/R2/R5: load with pol=1, count boundary
        line_i = rand_line(); pol_sel_i = 1'b1; load_i = 1'b1;
        tick("R1", "R2", "R5");
        load_i = 1'b0;
        ticks(ST - 2, "R8", "R8", "R5");
        tick("R8", "R8", "R5");               // 252nd edge: low
        tick("R8", "R8", "R5");               // 253rd edge: high
        chk_ready("R5", 1'b1);
        ticks(4, "R8", "R8", "R5");

        // R4: strobe held high, line and pol change while held
        nl = rand_line();
        line_i = nl; pol_sel_i = 1'b0; load_i = 1'b1;
        tick("R1", "R2", "R6");
        line_i = rand_line(); pol_sel_i = 1'b1;
        ticks(4, "R4", "R4", "R5");
        chk_codes("R4", nl);
        load_i = 1'b0;
        ticks(3, "R4", "R4", "R5");

        // R6: reload mid-count
        ticks(100, "R8", "R8", "R5");
        line_i = rand_line(); load_i = 1'b1;
        tick("R1", "R2", "R6");
        chk_ready("R6", 1'b0);
        load_i = 1'b0;
        ticks(ST - 1, "R8", "R8", "R6");
        chk_ready("R6", 1'b0);
        tick("R8", "R8", "R6");
        chk_ready("R6", 1'b1);

        // R3: partial refill while capture busy
        cap_busy_i = 1'b1;
        nl = line_i;
        for (int i = 0; i < 5; i++) nl[i*W +: W] = W'($urandom);
        line_i = nl; load_i = 1'b1;
        tick("R3", "R2", "R6");
        chk_codes("R3", nl);
        load_i = 1'b0; cap_busy_i = 1'b0;
        tick("R8", "R8", "R5");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int hold, gap;
            hold = 1 + ($urandom % 3);
            gap  = 1 + ($urandom % 300);
            cap_busy_i = $urandom % 2;
            pol_sel_i  = $urandom % 2;
            line_i     = rand_line();
            load_i     = 1'b1;
            for (int h = 0; h < hold; h++) begin
                tick("R1", "R2", "R6");
                if (h == 0) begin
                    line_i = rand_line();
                    pol_sel_i = ~pol_sel_i;
                end
            end
            load_i = 1'b0;
            cap_busy_i = $urandom % 2;
            ticks(gap, "R8", "R8", "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule